// File: doc/BRIEF.md
# Timer Schedule Entry Matcher

This block decides, once per minute, whether a single packed timer schedule entry should launch its start event or its stop event. The entry is a 72-bit word that carries a weekday mask, a day-of-year window, a start time and a stop time, and a 12-bit macro pointer for each event. The current calendar position arrives as a separate bundle: a one-hot weekday, a 9-bit day of year, a two-hour slot count and a minute remainder from 0 to 119.

A surrounding sequencer presents one entry per minute tick and stops stepping when it meets an entry whose top byte is all ones. On each tick the matcher registers both macro pointers and raises a one-cycle fire pulse for each event whose conditions hold. Holding the clock, walking the table and running the macro are done elsewhere.

Top module: `sched_entry_matcher`

## Requirements
- R1: While `rstN` is low, `startFire` and `stopFire` are 0 and both pointer outputs are 0.
- R2: On a clock edge with `minuteTick` high, `startFire` is 1 in the following cycle when the weekday gate and day window both hold and the current minute of day (`nowHalfHours`*120 + `nowMinutes`) equals the start time. If the minute of day differs, `startFire` is 0.
- R3: Under the same gating, `stopFire` is 1 in the cycle after the tick when the current minute of day equals the stop time.
- R4: Neither event fires unless the entry bit 64+k is set for the set bit k of `nowDow` (k = 0 is Sunday, k = 6 is Saturday). Entry bits 70..64 form this mask.
- R5: When the start day is not greater than the stop day, the window covers start day through stop day, both ends included.
- R6: When the start day is greater than the stop day, the window wraps across year end: a day matches if it is at or after the start day, or at or before the stop day.
- R7: An entry whose bits 71..64 equal 8'hFF marks the end of the table and never fires, whatever its other fields hold.
- R8: On every tick, `startPtr` loads {entry[23:20], entry[15:8]} and `stopPtr` loads {entry[19:16], entry[7:0]}. Between ticks both pointers hold their value.
- R9: Without a tick, no fire pulse is raised, and each pulse lasts exactly one cycle unless the next cycle also has a matching tick.
- R10: When the start time equals the stop time and the gates hold, both pulses rise in the same cycle.
- R11: The start day is {entry[39], entry[63:56]} and the stop day is {entry[31], entry[55:48]}. The start time is entry[47:44]*120 + entry[38:32] and the stop time is entry[43:40]*120 + entry[30:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| minuteTick | input | 1 | One-cycle strobe, one per minute |
| entry | input | 72 | Packed schedule entry |
| nowDow | input | 7 | Current weekday, one-hot, bit 0 Sunday |
| nowDay | input | 9 | Current day of year |
| nowHalfHours | input | 4 | Current hours divided by two, 0..11 |
| nowMinutes | input | 7 | Minutes into the current two-hour slot, 0..119 |
| startFire | output | 1 | Start event pulse |
| stopFire | output | 1 | Stop event pulse |
| startPtr | output | 12 | Start macro pointer |
| stopPtr | output | 12 | Stop macro pointer |

## Verification
The start and stop events can fire in the same cycle when an entry's start time equals its stop time. The bench provokes this with a wrapping day window and times set equal, and probes days inside the window, at both of its ends and outside it. Each tick is judged by comparing both pulses and both pointers against values the bench derives from the entry fields. The pulses are expected together when the gates hold and both absent otherwise.

// File: rtl/sched_match_pkg.sv
package sched_match_pkg;
  localparam int ENTRY_W = 72;

  typedef struct packed {
    logic capture;
    logic setStart;
    logic setStop;
  } schedStrobe_t;
endpackage

// File: rtl/sched_match_datapath.sv
module sched_match_datapath
  import sched_match_pkg::*;
#(
  parameter int DOW_N    = 7,
  parameter int DAY_W    = 9,
  parameter int HALF_W   = 4,
  parameter int MIN_W    = 7,
  parameter int PTR_W    = 12,
  parameter int SLOT_MIN = 120
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [DOW_N-1:0]   nowDow,
  input  logic [DAY_W-1:0]   nowDay,
  input  logic [HALF_W-1:0]  nowHalfHours,
  input  logic [MIN_W-1:0]   nowMinutes,
  input  schedStrobe_t       strobe,
  output logic               startHit,
  output logic               stopHit,
  output logic               isEnd,
  output logic               startFire,
  output logic               stopFire,
  output logic [PTR_W-1:0]   startPtr,
  output logic [PTR_W-1:0]   stopPtr
);
  localparam int TIME_W = $clog2((2**HALF_W) * SLOT_MIN + 2**MIN_W);
  localparam int N_EV   = 2;  // index 0 start, index 1 stop

  logic [DOW_N-1:0]  dowMask;
  logic [DAY_W-1:0]  dayFirst, dayLast;
  logic [HALF_W-1:0] evSlot   [N_EV];
  logic [MIN_W-1:0]  evRemain [N_EV];
  logic [TIME_W-1:0] evTime   [N_EV];
  logic [N_EV-1:0]   timeHit;
  logic [TIME_W-1:0] curTime;
  logic              dowOk, inWindow;
  logic [PTR_W-1:0]  ptrStartNext, ptrStopNext;

  // field extraction
  assign dowMask      = entry[70:64];
  assign dayFirst     = {entry[39], entry[63:56]};
  assign dayLast      = {entry[31], entry[55:48]};
  assign evSlot[0]    = entry[47:44];
  assign evSlot[1]    = entry[43:40];
  assign evRemain[0]  = entry[38:32];
  assign evRemain[1]  = entry[30:24];
  assign ptrStartNext = {entry[23:20], entry[15:8]};
  assign ptrStopNext  = {entry[19:16], entry[7:0]};
  assign isEnd        = (entry[71:64] == 8'hFF);

  assign curTime = TIME_W'(nowHalfHours) * TIME_W'(SLOT_MIN) + TIME_W'(nowMinutes);

  for (genvar ev = 0; ev < N_EV; ev++) begin : g_event
    assign evTime[ev]  = TIME_W'(evSlot[ev]) * TIME_W'(SLOT_MIN) + TIME_W'(evRemain[ev]);
    assign timeHit[ev] = (evTime[ev] == curTime);
  end

  assign dowOk = |(dowMask & nowDow);

  always_comb begin
    if (dayFirst <= dayLast)
      inWindow = (nowDay >= dayFirst) && (nowDay <= dayLast);
    else
      inWindow = (nowDay >= dayFirst) || (nowDay <= dayLast);
  end

  assign startHit = dowOk && inWindow && timeHit[0];
  assign stopHit  = dowOk && inWindow && timeHit[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startFire <= 1'b0;
      stopFire  <= 1'b0;
      startPtr  <= '0;
      stopPtr   <= '0;
    end else begin
      startFire <= strobe.setStart;
      stopFire  <= strobe.setStop;
      if (strobe.capture) begin
        startPtr <= ptrStartNext;
        stopPtr  <= ptrStopNext;
      end
    end
  end
endmodule

// File: rtl/sched_match_ctrl.sv
module sched_match_ctrl
  import sched_match_pkg::*;
(
  input  logic         minuteTick,
  input  logic         startHit,
  input  logic         stopHit,
  input  logic         isEnd,
  output schedStrobe_t strobe
);
  logic live;

  assign live = minuteTick && !isEnd;

  always_comb begin
    strobe          = '0;
    strobe.capture  = minuteTick;
    strobe.setStart = live && startHit;
    strobe.setStop  = live && stopHit;
  end
endmodule

// File: rtl/sched_entry_matcher.sv
module sched_entry_matcher
  import sched_match_pkg::*;
#(
  parameter int DOW_N    = 7,
  parameter int DAY_W    = 9,
  parameter int HALF_W   = 4,
  parameter int MIN_W    = 7,
  parameter int PTR_W    = 12,
  parameter int SLOT_MIN = 120
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               minuteTick,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [DOW_N-1:0]   nowDow,
  input  logic [DAY_W-1:0]   nowDay,
  input  logic [HALF_W-1:0]  nowHalfHours,
  input  logic [MIN_W-1:0]   nowMinutes,
  output logic               startFire,
  output logic               stopFire,
  output logic [PTR_W-1:0]   startPtr,
  output logic [PTR_W-1:0]   stopPtr
);
  schedStrobe_t strobe;
  logic startHit, stopHit, isEnd;

  sched_match_ctrl u_ctrl (
    .minuteTick (minuteTick),
    .startHit   (startHit),
    .stopHit    (stopHit),
    .isEnd      (isEnd),
    .strobe     (strobe)
  );

  sched_match_datapath #(
    .DOW_N(DOW_N), .DAY_W(DAY_W), .HALF_W(HALF_W),
    .MIN_W(MIN_W), .PTR_W(PTR_W), .SLOT_MIN(SLOT_MIN)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .entry        (entry),
    .nowDow       (nowDow),
    .nowDay       (nowDay),
    .nowHalfHours (nowHalfHours),
    .nowMinutes   (nowMinutes),
    .strobe       (strobe),
    .startHit     (startHit),
    .stopHit      (stopHit),
    .isEnd        (isEnd),
    .startFire    (startFire),
    .stopFire     (stopFire),
    .startPtr     (startPtr),
    .stopPtr      (stopPtr)
  );
endmodule

// File: rtl/sched_match_checker.sv
module sched_match_checker
  import sched_match_pkg::*;
#(
  parameter int DOW_N  = 7,
  parameter int DAY_W  = 9,
  parameter int HALF_W = 4,
  parameter int MIN_W  = 7,
  parameter int PTR_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               minuteTick,
  input logic [ENTRY_W-1:0] entry,
  input logic [DOW_N-1:0]   nowDow,
  input logic [DAY_W-1:0]   nowDay,
  input logic [HALF_W-1:0]  nowHalfHours,
  input logic [MIN_W-1:0]   nowMinutes,
  input logic               startFire,
  input logic               stopFire,
  input logic [PTR_W-1:0]   startPtr,
  input logic [PTR_W-1:0]   stopPtr
);
  // R9: no tick, no pulse in the next cycle
  assert_no_tick_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !minuteTick |=> (!startFire && !stopFire));

  // R8: pointers hold between ticks
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !minuteTick |=> ($stable(startPtr) && $stable(stopPtr)));

  // R8: pointers taken from the entry on a tick
  assert_ptr_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    minuteTick |=> (startPtr == $past({entry[23:20], entry[15:8]}) &&
                    stopPtr  == $past({entry[19:16], entry[7:0]})));

  // R7: end-of-table entry never fires
  assert_end_marker_R7: assert property (@(posedge clk) disable iff (!rstN)
    (minuteTick && entry[71:64] == 8'hFF) |=> (!startFire && !stopFire));

  // R4: weekday gate
  assert_dow_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (minuteTick && (entry[70:64] & nowDow) == '0) |=> (!startFire && !stopFire));

  // R1: outputs cleared by reset
  always @(posedge clk) begin
    if (rstN && !$past(rstN)) begin
      assert_reset_clear_R1: assert (!startFire && !stopFire && startPtr == '0 && stopPtr == '0);
    end
  end
endmodule

bind sched_entry_matcher sched_match_checker #(
  .DOW_N(DOW_N), .DAY_W(DAY_W), .HALF_W(HALF_W), .MIN_W(MIN_W), .PTR_W(PTR_W)
) u_chk (.*);

// File: tb/sched_entry_matcher_bench.sv
module sched_entry_matcher_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        minuteTick;
  logic [71:0] entry;
  logic [6:0]  nowDow;
  logic [8:0]  nowDay;
  logic [3:0]  nowHalfHours;
  logic [6:0]  nowMinutes;
  logic        startFire, stopFire;
  logic [11:0] startPtr, stopPtr;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sched_entry_matcher u_sched_entry_matcher (.*);

  function automatic logic [71:0] mkEntry(
    logic [6:0] dow, logic [8:0] sDay, logic [8:0] eDay,
    logic [3:0] sSlot, logic [6:0] sRem, logic [3:0] eSlot, logic [6:0] eRem,
    logic [11:0] sPtr, logic [11:0] ePtr);
    logic [71:0] e;
    e = '0;
    e[70:64] = dow;
    e[63:56] = sDay[7:0];  e[39] = sDay[8];
    e[55:48] = eDay[7:0];  e[31] = eDay[8];
    e[47:44] = sSlot;      e[38:32] = sRem;
    e[43:40] = eSlot;      e[30:24] = eRem;
    e[23:20] = sPtr[11:8]; e[15:8] = sPtr[7:0];
    e[19:16] = ePtr[11:8]; e[7:0]  = ePtr[7:0];
    return e;
  endfunction

  typedef struct packed {
    logic [71:0] ent;
    logic [6:0]  dow;
    logic [8:0]  day;
    logic [3:0]  half;
    logic [6:0]  mins;
    logic        expS;
    logic        expE;
    logic [7:0]  req;
  } vec_t;

  localparam logic [71:0] EA = mkEntry(7'b0111110, 9'd0, 9'd365, 4'd4, 7'd0, 4'd9, 7'd0, 12'h01D, 12'h022);
  localparam logic [71:0] EB = mkEntry(7'h7F, 9'd100, 9'd200, 4'd1, 7'd5, 4'd11, 7'd119, 12'hABC, 12'h123);
  localparam logic [71:0] EC = mkEntry(7'h7F, 9'd300, 9'd20, 4'd5, 7'd0, 4'd5, 7'd0, 12'h5A5, 12'hF0F);
  localparam logic [71:0] ED = mkEntry(7'b1000000, 9'd256, 9'd256, 4'd0, 7'd0, 4'd1, 7'd10, 12'h800, 12'h0FF);
  localparam logic [71:0] EE = mkEntry(7'h7F, 9'd0, 9'd365, 4'd0, 7'd0, 4'd0, 7'd0, 12'h111, 12'h222)
                               | (72'd1 << 71);

  localparam int NV = 21;
  // R2 R3 R4 R5 R6 R7 R10 R11 vectors
  localparam vec_t VECS [NV] = '{
    '{EA, 7'b0000010, 9'd10,  4'd4,  7'd0,   1'b1, 1'b0, 8'd2},
    '{EA, 7'b0000010, 9'd10,  4'd9,  7'd0,   1'b0, 1'b1, 8'd3},
    '{EA, 7'b0000001, 9'd10,  4'd4,  7'd0,   1'b0, 1'b0, 8'd4},
    '{EA, 7'b0000010, 9'd10,  4'd4,  7'd1,   1'b0, 1'b0, 8'd2},
    '{EA, 7'b0100000, 9'd365, 4'd9,  7'd0,   1'b0, 1'b1, 8'd5},
    '{EB, 7'b0000001, 9'd99,  4'd1,  7'd5,   1'b0, 1'b0, 8'd5},
    '{EB, 7'b0000001, 9'd100, 4'd1,  7'd5,   1'b1, 1'b0, 8'd5},
    '{EB, 7'b0001000, 9'd200, 4'd11, 7'd119, 1'b0, 1'b1, 8'd5},
    '{EB, 7'b0001000, 9'd201, 4'd11, 7'd119, 1'b0, 1'b0, 8'd5},
    '{EB, 7'b0000100, 9'd150, 4'd1,  7'd4,   1'b0, 1'b0, 8'd11},
    '{EC, 7'b0010000, 9'd310, 4'd5,  7'd0,   1'b1, 1'b1, 8'd10},
    '{EC, 7'b0010000, 9'd5,   4'd5,  7'd0,   1'b1, 1'b1, 8'd6},
    '{EC, 7'b0010000, 9'd150, 4'd5,  7'd0,   1'b0, 1'b0, 8'd6},
    '{EC, 7'b0010000, 9'd300, 4'd5,  7'd0,   1'b1, 1'b1, 8'd6},
    '{EC, 7'b0010000, 9'd20,  4'd5,  7'd0,   1'b1, 1'b1, 8'd6},
    '{EC, 7'b0010000, 9'd21,  4'd5,  7'd0,   1'b0, 1'b0, 8'd6},
    '{ED, 7'b1000000, 9'd256, 4'd1,  7'd10,  1'b0, 1'b1, 8'd11},
    '{ED, 7'b1000000, 9'd0,   4'd1,  7'd10,  1'b0, 1'b0, 8'd11},
    '{ED, 7'b0100000, 9'd256, 4'd0,  7'd0,   1'b0, 1'b0, 8'd4},
    '{ED, 7'b1000000, 9'd256, 4'd0,  7'd0,   1'b1, 1'b0, 8'd11},
    '{EE, 7'b0000001, 9'd1,   4'd0,  7'd0,   1'b0, 1'b0, 8'd7}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic tick);
    entry        = v.ent;
    nowDow       = v.dow;
    nowDay       = v.day;
    nowHalfHours = v.half;
    nowMinutes   = v.mins;
    minuteTick   = tick;
  endtask

  initial begin
    rstN = 1'b0;
    drive(VECS[0], 1'b1);
    repeat (3) @(negedge clk);
    // R1: reset state even with a matching tick present
    check("R1", startFire, 0, "startFire");
    check("R1", stopFire, 0, "stopFire");
    check("R1", startPtr, 0, "startPtr");
    check("R1", stopPtr, 0, "stopPtr");
    minuteTick = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      drive(VECS[i], 1'b1);
      @(negedge clk);
      minuteTick = 1'b0;
      check(tag, startFire, VECS[i].expS, "startFire");
      check(tag, stopFire, VECS[i].expE, "stopFire");
      // R8: pointer fields
      check("R8", startPtr, {VECS[i].ent[23:20], VECS[i].ent[15:8]}, "startPtr");
      check("R8", stopPtr, {VECS[i].ent[19:16], VECS[i].ent[7:0]}, "stopPtr");
      @(negedge clk);
      // R9: pulse is one cycle long
      check("R9", {31'd0, startFire | stopFire}, 0, "pulse after tick");
    end

    // R9 / R8: matching inputs without a tick
    drive(VECS[0], 1'b0);
    repeat (2) @(negedge clk);
    check("R9", startFire, 0, "startFire no tick");
    check("R8", startPtr, 12'h111, "startPtr hold");
    check("R8", stopPtr, 12'h222, "stopPtr hold");

    // R10: back-to-back ticks with both events matching
    drive(VECS[10], 1'b1);
    @(negedge clk);
    check("R10", {startFire, stopFire}, 2'b11, "both tick1");
    @(negedge clk);
    check("R10", {startFire, stopFire}, 2'b11, "both tick2");
    minuteTick = 1'b0;

    // R1: reset during a run clears pulses and pointers
    rstN = 1'b0;
    @(negedge clk);
    check("R1", startPtr, 0, "startPtr after reset");
    check("R1", {startFire, stopFire}, 0, "fires after reset");
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule